// File: doc/BRIEF.md
# Symbol Rate Strobe Generator

This block paces a transmit interpolation chain. A 32-bit phase accumulator, or a 16-bit rollover counter when that mode is selected, produces a top-rate tick. A free-running divider turns the tick into a set of single-cycle clock-enable strobes at the symbol rate times 1, 2, 4, 8, 16 and 32. A separate strobe at twice the symbol rate drives an external data-clock pin.

The accumulator step is the programmed frequency word. A signed correction from an external phase-lock loop can be added to it under an enable bit. A filter-chain configuration code sets how many times faster than the symbol rate the top-rate tick runs. Software therefore programs the step as (2^k · symbol rate / output sample rate) · 2^32, where 2^k is the rate multiple that the configuration selects.

Top module: `symbol_rate_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, the counter and the divider clear. All strobe outputs are 0 in the cycle after that edge.
- R2: When `mode_i`=0, a top-rate tick occurs at every rising edge where the 32-bit sum of the accumulator and the effective step carries out. From reset with a constant step S, N edges give floor(N·S/2^32) ticks.
- R3: When `loop_en_i`=1, the effective step is `step_i` + `loop_err_i` modulo 2^32, where `loop_err_i` is two's complement.
- R4: When `loop_en_i`=0, `loop_err_i` has no effect on any output.
- R5: When `mode_i`=1, the counter starts at 0 and ticks at every edge where its count is at or above `rollover_i`. It then returns to 0; otherwise it increments. The tick period is `rollover_i`+1 edges.
- R6: The rate shift M is decoded from the configuration, with `fir_interp_i` codes 0,1,2,3 meaning FIR x2,x4,x8,x16. With both bypass bits set, M=0. With only `fir_bypass_i` set, M=1. With only `hb_bypass_i` set, M=2,2,3,4. With neither set, M=2,3,4,5.
- R7: Bit k of `rate_strb_o` is the symbol rate times 2^k. For k≤M it is high in the cycle after the n-th tick since reset exactly when n is a multiple of 2^(M-k). For k>M it stays 0.
- R8: The strobes are phase aligned. Bit M goes high on the 1st tick, and bit 0 goes high first on tick 2^M. Whenever a lower-rate strobe is high, every enabled higher-rate strobe is high in the same cycle.
- R9: `pin2x_o` equals bit 1 of `rate_strb_o` in every cycle. It is therefore 0 when M=0.
- R10: A change of `step_i` or `rollover_i` applies from the next rising edge, without clearing the accumulator or counter. If the count is already at or above a new rollover value, the next edge ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 32 | Programmed frequency step |
| loop_err_i | input | 32 | Signed loop correction term |
| loop_en_i | input | 1 | Adds the loop correction when 1 |
| mode_i | input | 1 | 0 selects the accumulator, 1 selects the rollover counter |
| rollover_i | input | 16 | Counter rollover value |
| fir_bypass_i | input | 1 | Shaping filter bypassed |
| hb_bypass_i | input | 1 | Halfband filter bypassed |
| fir_interp_i | input | 2 | FIR interpolation code (x2,x4,x8,x16) |
| rate_strb_o | output | 6 | Strobes at symbol rate times 2^k, bit k |
| pin2x_o | output | 1 | Twice-symbol-rate strobe for the data-clock pin |

## Verification
The bench sweeps every bypass and interpolation combination in both tick modes, comparing each cycle against a tick-count model. An error in the decode table would show up as strobes on the wrong bits or at the wrong ratio. A divider that is not reset-aligned would place the first symbol strobe off tick 2^M. Directed cases check the following:
- The carry count with the loop term both enabled (as a negative correction) and disabled. A missing sign extension or a leaked error term changes the tick count.
- Runtime changes of the step and the rollover value, including a rollover lowered below the current count. A design that clears its state on a change, or waits for an exact match, delays the next tick.

// File: rtl/srg_pkg.sv
package srg_pkg;

    localparam int RATE_LEVELS = 6;
    localparam int RATE_W      = 3;

    typedef enum logic [1:0] {
        FIR_X2  = 2'd0,
        FIR_X4  = 2'd1,
        FIR_X8  = 2'd2,
        FIR_X16 = 2'd3
    } fir_interp_e;

    typedef enum logic {
        SRC_PHASE = 1'b0,
        SRC_COUNT = 1'b1
    } tick_src_e;

    typedef struct packed {
        logic        fir_bypass;
        logic        hb_bypass;
        fir_interp_e interp;
    } chain_cfg_t;

    // log2 of the top-rate tick over the symbol rate
    function automatic logic [RATE_W-1:0] rate_shift(chain_cfg_t c);
        logic [RATE_W-1:0] s;
        if (c.fir_bypass && c.hb_bypass) begin
            s = 3'd0;
        end else if (c.fir_bypass) begin
            s = 3'd1;
        end else if (c.hb_bypass) begin
            case (c.interp)
                FIR_X2:  s = 3'd2;
                FIR_X4:  s = 3'd2;
                FIR_X8:  s = 3'd3;
                default: s = 3'd4;
            endcase
        end else begin
            s = {1'b0, c.interp} + 3'd2;
        end
        return s;
    endfunction

endpackage

// File: rtl/srg_phase_acc.sv
module srg_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step_i,
    input  logic [PHASE_W-1:0] err_i,
    input  logic               err_en_i,
    output logic               tick_o
);
    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] eff_step;
    logic [PHASE_W-1:0] sum;
    logic               carry;

    always_comb begin
        eff_step       = err_en_i ? (step_i + err_i) : step_i;
        {carry, sum}   = {1'b0, acc_q} + {1'b0, eff_step};
    end

    assign tick_o = carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum;
        end
    end

    // R2
    acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (acc_q < $past(acc_q)));

endmodule

// File: rtl/srg_roll_counter.sv
module srg_roll_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] roll_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= roll_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R5
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/srg_rate_divider.sv
module srg_rate_divider
    import srg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_i,
    input  logic [RATE_W-1:0]      shift_i,
    output logic [RATE_LEVELS-1:0] strb_o
);
    localparam int DIV_W = RATE_LEVELS - 1;

    logic [DIV_W-1:0]       div_q;
    logic [RATE_W-1:0]      rate_q;
    logic [RATE_LEVELS-1:0] strb_q;
    logic [RATE_LEVELS-1:0] hit;
    logic [DIV_W-1:0]       need;

    always_comb begin
        need = '0;
        for (int k = 0; k < RATE_LEVELS; k++) begin
            hit[k] = 1'b0;
            need   = '0;
            if (tick_i && (RATE_W'(k) <= shift_i)) begin
                need   = (DIV_W'(1) << (shift_i - RATE_W'(k))) - DIV_W'(1);
                hit[k] = ((div_q & need) == need);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            rate_q <= '0;
            strb_q <= '0;
        end else begin
            div_q  <= div_q + DIV_W'(tick_i);
            rate_q <= shift_i;
            strb_q <= hit;
        end
    end

    assign strb_o = strb_q;

    for (genvar k = 1; k < RATE_LEVELS; k++) begin : g_nest
        // R8
        nest_chk: assert property (@(posedge clk) disable iff (rst)
            (strb_q[k-1] && (RATE_W'(k) <= rate_q)) |-> strb_q[k]);
    end

    for (genvar k = 0; k < RATE_LEVELS; k++) begin : g_above
        // R7
        above_rate_chk: assert property (@(posedge clk) disable iff (rst)
            (RATE_W'(k) > rate_q) |-> !strb_q[k]);
    end

endmodule

// File: rtl/symbol_rate_strobe_gen.sv
module symbol_rate_strobe_gen
    import srg_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int CNT_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PHASE_W-1:0]     step_i,
    input  logic [PHASE_W-1:0]     loop_err_i,
    input  logic                   loop_en_i,
    input  logic                   mode_i,
    input  logic [CNT_W-1:0]       rollover_i,
    input  logic                   fir_bypass_i,
    input  logic                   hb_bypass_i,
    input  logic [1:0]             fir_interp_i,
    output logic [RATE_LEVELS-1:0] rate_strb_o,
    output logic                   pin2x_o
);
    chain_cfg_t        cfg;
    tick_src_e         src;
    logic              phase_tick;
    logic              count_tick;
    logic              top_tick;
    logic [RATE_W-1:0] shift;

    assign cfg   = '{fir_bypass: fir_bypass_i, hb_bypass: hb_bypass_i,
                     interp: fir_interp_e'(fir_interp_i)};
    assign src   = tick_src_e'(mode_i);
    assign shift = rate_shift(cfg);

    srg_phase_acc #(.PHASE_W(PHASE_W)) acc_i (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_i),
        .err_i   (loop_err_i),
        .err_en_i(loop_en_i),
        .tick_o  (phase_tick)
    );

    srg_roll_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .roll_i(rollover_i),
        .tick_o(count_tick)
    );

    assign top_tick = (src == SRC_COUNT) ? count_tick : phase_tick;

    srg_rate_divider div_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (top_tick),
        .shift_i(shift),
        .strb_o (rate_strb_o)
    );

    assign pin2x_o = rate_strb_o[1];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (rate_strb_o == '0));

endmodule

// File: tb/symbol_rate_strobe_gen_tb.sv
`timescale 1ns/1ps
module symbol_rate_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] step = '0;
    logic [31:0] err = '0;
    logic        loop_en = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] roll = '0;
    logic        fb = 1'b0;
    logic        hb = 1'b0;
    logic [1:0]  interp = '0;
    logic [5:0]  strb;
    logic        pin2x;

    int nchecks = 0;
    int nerrors = 0;

    always #2.5 clk = ~clk;

    symbol_rate_strobe_gen dut_i (
        .clk(clk), .rst(rst), .step_i(step), .loop_err_i(err),
        .loop_en_i(loop_en), .mode_i(mode), .rollover_i(roll),
        .fir_bypass_i(fb), .hb_bypass_i(hb), .fir_interp_i(interp),
        .rate_strb_o(strb), .pin2x_o(pin2x)
    );

    // rate shift table taken from R6
    function automatic int bench_shift(logic f, logic h, logic [1:0] c);
        if (f && h) return 0;
        if (f) return 1;
        if (h) begin
            if (c <= 2'd1) return 2;
            return int'(c) + 1;
        end
        return int'(c) + 2;
    endfunction

    // behavioural model built from R2, R3, R5, R7
    longint    macc;
    longint    mcnt;
    longint    mticks;
    logic [5:0] mexp;

    always @(posedge clk) begin
        if (rst) begin
            macc = 0; mcnt = 0; mticks = 0; mexp = '0;
        end else begin
            longint eff;
            logic   t;
            int     m;
            eff = loop_en ? ((longint'(step) + longint'($signed(err))) & 64'hFFFF_FFFF)
                          : longint'(step);
            m = bench_shift(fb, hb, interp);
            if (mode) begin
                t = (mcnt >= longint'(roll));
                mcnt = t ? 0 : mcnt + 1;
            end else begin
                t = ((macc + eff) >= 64'h1_0000_0000);
                macc = (macc + eff) & 64'hFFFF_FFFF;
            end
            if (t) mticks = mticks + 1;
            for (int k = 0; k < 6; k++)
                mexp[k] = t && (k <= m) && ((mticks % (longint'(1) << (m - k))) == 0);
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 strobes in reset", longint'({pin2x, strb}), 0);
        rst = 1'b0;
    endtask

    task automatic run(input int n, input string tag, output longint top_c,
                       output longint sym_c, output int first_top, output int first_sym);
        int m;
        m = bench_shift(fb, hb, interp);
        top_c = 0; sym_c = 0; first_top = -1; first_sym = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check(tag, longint'(strb), longint'(mexp));
            check("R9 pin2x", longint'(pin2x), longint'(strb[1]));
            if (strb[m]) begin
                top_c++;
                if (first_top < 0) first_top = i;
            end
            if (strb[0]) begin
                sym_c++;
                if (first_sym < 0) first_sym = i;
            end
        end
    endtask

    initial begin
        #(5ns * 150000);
        nerrors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        longint tc, sc;
        int     ft, fs, m;

        @(negedge clk);
        do_reset();

        // sweep all configurations in both modes: R6 R7 R8 R9
        for (int md = 0; md < 2; md++) begin
            for (int cf = 0; cf < 16; cf++) begin
                rst = 1'b1;
                fb = cf[3]; hb = cf[2]; interp = cf[1:0];
                mode = md[0]; loop_en = 1'b0; err = 32'h1234_5678;
                step = 32'h4000_0123;
                roll = 16'(1 + (cf % 3));
                do_reset();
                m = bench_shift(fb, hb, interp);
                run(260, "R7 R8 sweep strobes", tc, sc, ft, fs);
                if (md == 0)
                    check("R2 R6 top ticks", tc, (longint'(260) * longint'(step)) >> 32);
                else begin
                    check("R5 R6 top ticks", tc, 260 / (longint'(roll) + 1));
                    check("R8 first symbol strobe", longint'(fs),
                          ((longint'(1) << m) * (longint'(roll) + 1) <= 260) ?
                          (longint'(1) << m) * (longint'(roll) + 1) : -1);
                end
                check("R7 symbol ticks", sc, tc >> m);
            end
        end

        // R8: tick every edge, M=5, all strobes together on tick 32
        fb = 0; hb = 0; interp = 2'd3; mode = 1; roll = 0;
        do_reset();
        run(31, "R8 aligned", tc, sc, ft, fs);
        check("R8 no symbol before tick 32", sc, 0);
        @(negedge clk);
        check("R8 all strobes on tick 32", longint'(strb), 63);

        // R3: loop term enabled, negative correction
        fb = 1; hb = 1; mode = 0; loop_en = 1;
        step = 32'h5000_0000; err = 32'hF000_0000;
        do_reset();
        run(400, "R3 loop on", tc, sc, ft, fs);
        check("R3 ticks with correction", tc, 100);

        // R4: loop term disabled, large error ignored
        loop_en = 0; step = 32'h3000_0000; err = 32'h7FFF_FFFF;
        do_reset();
        run(400, "R4 loop off", tc, sc, ft, fs);
        check("R4 ticks without correction", tc, 75);

        // R10: step change keeps the accumulator
        step = 32'h8000_0000;
        do_reset();
        run(3, "R10 step phase a", tc, sc, ft, fs);
        check("R10 ticks before change", tc, 1);
        step = 32'h4000_0000;
        run(2, "R10 step phase b", tc, sc, ft, fs);
        check("R10 ticks after step change", tc, 1);

        // R10: rollover change keeps the count
        mode = 1; roll = 16'd4;
        do_reset();
        run(3, "R10 roll phase a", tc, sc, ft, fs);
        roll = 16'd3;
        run(6, "R10 roll phase b", tc, sc, ft, fs);
        check("R10 first tick after roll change", longint'(ft), 1);

        // R10: rollover lowered below current count
        roll = 16'd6;
        do_reset();
        run(5, "R10 roll lower a", tc, sc, ft, fs);
        check("R10 no tick before lowering", tc, 0);
        roll = 16'd2;
        run(4, "R10 roll lower b", tc, sc, ft, fs);
        check("R10 tick right after lowering", longint'(ft), 1);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule